// File: doc/BRIEF.md
# Piecewise-Planar Approximate Divider

This block divides one unsigned integer by another in a single pass, with no iteration and no subtraction loop. It is meant for pixel-rate filter datapaths, where a quotient with a known small relative error can replace an exact division. A new division can start on every clock, and each result leaves the pipeline after a fixed latency. There is no stall input.

Both operands are normalized to a mantissa in [1,2) with a leading-one detector. The top fraction bits of the two mantissas together select one of a small set of regions of the quotient surface x/y. Each region holds a plane, offset plus two slopes, whose coefficients are computed at elaboration as the tangent plane at the region centre. The plane is evaluated with two multiplies and an add. The normalized result is then shifted by the difference of the two exponents and truncated to an integer. A zero divisor saturates the quotient and raises a flag.

Top module: `apxdiv_top`

## Requirements
- R1: A division presented with `valid_i` high is sampled on a rising edge. Its result and `valid_o` are registered on the third rising edge counting that one. `valid_o` is low in every cycle with no matching input, and back-to-back inputs give back-to-back outputs.
- R2: For a nonzero divisor, the output q and the exact floor quotient e = floor(dividend/divisor) satisfy 16*|q - e| <= e + 16.
- R3: A zero divisor gives `quot_o` all ones (0xFFFF at the default width) with `dz_o` high, whatever the dividend.
- R4: `dz_o` is low for every result whose divisor was nonzero, and whenever `valid_o` is low.
- R5: A zero dividend with a nonzero divisor gives exactly 0.
- R6: Equal nonzero operands give exactly 1.
- R7: When both operands are powers of two, the result equals the exact floor quotient. This includes results below one, which give 0.
- R8: While `rst_ni` is low, `valid_o`, `dz_o` and `quot_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands below are valid this cycle |
| dividend_i | input | OP_W | Unsigned dividend |
| divisor_i | input | OP_W | Unsigned divisor |
| valid_o | output | 1 | Result on `quot_o` is valid |
| quot_o | output | OP_W | Approximate unsigned quotient |
| dz_o | output | 1 | Result came from a zero divisor |

## Verification
The hardest results to reach are those whose operand mantissas fall in the outer corners of a region, far from the tangent point, while the exponents differ widely. Plain uniform operands almost always have a 16-bit dividend and divisor, so the exponent difference stays near zero. The stimulus therefore masks each random operand to a random bit length, which spreads the exponent difference over its whole range. It also interleaves directed zero-divisor, zero-dividend, equal-operand and power-of-two cases into a stream with no gaps, so that the special-case flags must stay aligned with their own data through every stage.

// File: rtl/apxdiv_pkg.sv
package apxdiv_pkg;

  // Tangent-plane coefficient for region (ix, iy), scaled by 2^cf.
  // The region centres sit at a/u and b/u with u = 2^(ib+1).
  // sel 0: offset, sel 1: slope along the dividend fraction,
  // sel 2: magnitude of the (negative) slope along the divisor fraction.
  function automatic int unsigned plane_coef(int unsigned cf, int unsigned ib,
                                             int unsigned ix, int unsigned iy,
                                             int unsigned sel);
    longint unsigned u, a, b, num, den;
    u   = 64'd1 << (ib + 1);
    a   = u + 2 * longint'(ix) + 1;
    b   = u + 2 * longint'(iy) + 1;
    den = b * b;
    case (sel)
      0:       num = a * b + u * b - u * a;
      1:       num = u * b;
      default: num = u * a;
    endcase
    return 32'(((num << cf) + den / 2) / den);
  endfunction

endpackage

// File: rtl/apxdiv_lod.sv
module apxdiv_lod #(
  parameter int W  = 16,
  parameter int EW = $clog2(W)
) (
  input  logic [W-1:0]  op_i,
  output logic [EW-1:0] exp_o,
  output logic [W-2:0]  frac_o
);
  logic [W-1:0] norm;

  always_comb begin
    exp_o = '0;
    for (int i = 0; i < W; i++) begin
      if (op_i[i]) exp_o = EW'(i);
    end
  end

  // leading one moved to bit W-1; fraction is what lies below it
  assign norm   = op_i << (EW'(W - 1) - exp_o);
  assign frac_o = (W-1)'(norm);
endmodule

// File: rtl/apxdiv_plane.sv
module apxdiv_plane #(
  parameter int MW   = 15,
  parameter int CF   = 14,
  parameter int IB   = 2,
  localparam int CW   = CF + 1,
  localparam int QW   = CF + 2,
  localparam int NREG = 1 << (2 * IB)
) (
  input  logic [MW-1:0] fa_i,
  input  logic [MW-1:0] fb_i,
  output logic [QW-1:0] qn_o
);
  logic [CW-1:0]    c0_tab [NREG];
  logic [CW-1:0]    c1_tab [NREG];
  logic [CW-1:0]    c2_tab [NREG];
  logic [2*IB-1:0]  idx;
  logic [CW-1:0]    c0, c1, c2, t1, t2;
  logic [CW+MW-1:0] p1, p2;
  logic signed [CW+1:0] acc;

  for (genvar g = 0; g < NREG; g++) begin : g_tab
    assign c0_tab[g] = CW'(apxdiv_pkg::plane_coef(CF, IB, g >> IB, g % (1 << IB), 0));
    assign c1_tab[g] = CW'(apxdiv_pkg::plane_coef(CF, IB, g >> IB, g % (1 << IB), 1));
    assign c2_tab[g] = CW'(apxdiv_pkg::plane_coef(CF, IB, g >> IB, g % (1 << IB), 2));
  end

  // dividend bits select the row, divisor bits the column
  assign idx = {fa_i[MW-1 -: IB], fb_i[MW-1 -: IB]};
  assign c0  = c0_tab[idx];
  assign c1  = c1_tab[idx];
  assign c2  = c2_tab[idx];

  assign p1 = (CW+MW)'(c1) * (CW+MW)'(fa_i);
  assign p2 = (CW+MW)'(c2) * (CW+MW)'(fb_i);
  assign t1 = CW'(p1 >> MW);
  assign t2 = CW'(p2 >> MW);

  assign acc  = $signed({2'b00, c0}) + $signed({2'b00, t1}) - $signed({2'b00, t2});
  assign qn_o = acc[CW+1] ? '0 : QW'(acc);
endmodule

// File: rtl/apxdiv_denorm.sv
module apxdiv_denorm #(
  parameter int W  = 16,
  parameter int CF = 14,
  parameter int EW = $clog2(W),
  localparam int QW = CF + 2,
  localparam int XW = QW + W - 1
) (
  input  logic [QW-1:0]      qn_i,
  input  logic signed [EW:0] sh_i,
  output logic [W-1:0]       q_o
);
  logic [XW-1:0] ext, shifted;
  int            amt;

  // one right shift covers both signs of the exponent difference
  assign ext = {qn_i, {(W-1){1'b0}}};

  always_comb begin
    amt     = CF + W - 1 - int'(sh_i);
    shifted = ext >> amt;
    q_o     = (|(shifted >> W)) ? '1 : W'(shifted);
  end
endmodule

// File: rtl/apxdiv_top.sv
module apxdiv_top #(
  parameter int OP_W      = 16,
  parameter int COEF_FRAC = 14,
  parameter int IDX_BITS  = 2,
  localparam int EW = $clog2(OP_W),
  localparam int MW = OP_W - 1,
  localparam int QW = COEF_FRAC + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] dividend_i,
  input  logic [OP_W-1:0] divisor_i,
  output logic            valid_o,
  output logic [OP_W-1:0] quot_o,
  output logic            dz_o
);
  logic [EW-1:0] ea, eb;
  logic [MW-1:0] fa, fb;

  logic          s1_vld, s1_dz, s1_nz;
  logic [EW-1:0] s1_ea, s1_eb;
  logic [MW-1:0] s1_fa, s1_fb;

  logic              s2_vld, s2_dz, s2_nz;
  logic signed [EW:0] s2_sh;
  logic [QW-1:0]     s2_qn;

  logic [QW-1:0]   qn;
  logic [OP_W-1:0] dq;

  apxdiv_lod #(.W(OP_W), .EW(EW)) u_lod_a (.op_i(dividend_i), .exp_o(ea), .frac_o(fa));
  apxdiv_lod #(.W(OP_W), .EW(EW)) u_lod_b (.op_i(divisor_i),  .exp_o(eb), .frac_o(fb));

  // stage 1: normalized operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_dz  <= 1'b0;
      s1_nz  <= 1'b0;
      s1_ea  <= '0;
      s1_eb  <= '0;
      s1_fa  <= '0;
      s1_fb  <= '0;
    end else begin
      s1_vld <= valid_i;
      s1_dz  <= ~|divisor_i;
      s1_nz  <= ~|dividend_i;
      s1_ea  <= ea;
      s1_eb  <= eb;
      s1_fa  <= fa;
      s1_fb  <= fb;
    end
  end

  apxdiv_plane #(.MW(MW), .CF(COEF_FRAC), .IB(IDX_BITS)) u_plane (
    .fa_i(s1_fa), .fb_i(s1_fb), .qn_o(qn)
  );

  // stage 2: plane value and exponent difference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      s2_dz  <= 1'b0;
      s2_nz  <= 1'b0;
      s2_sh  <= '0;
      s2_qn  <= '0;
    end else begin
      s2_vld <= s1_vld;
      s2_dz  <= s1_dz;
      s2_nz  <= s1_nz;
      s2_sh  <= $signed({1'b0, s1_ea}) - $signed({1'b0, s1_eb});
      s2_qn  <= qn;
    end
  end

  apxdiv_denorm #(.W(OP_W), .CF(COEF_FRAC), .EW(EW)) u_denorm (
    .qn_i(s2_qn), .sh_i(s2_sh), .q_o(dq)
  );

  // stage 3: special cases and output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      quot_o  <= '0;
      dz_o    <= 1'b0;
    end else begin
      valid_o <= s2_vld;
      dz_o    <= s2_vld & s2_dz;
      if (s2_dz)      quot_o <= '1;
      else if (s2_nz) quot_o <= '0;
      else            quot_o <= dq;
    end
  end
endmodule

// File: rtl/apxdiv_chk.sv
module apxdiv_chk #(
  parameter int OP_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [OP_W-1:0] dividend_i,
  input logic [OP_W-1:0] divisor_i,
  input logic            valid_o,
  input logic [OP_W-1:0] quot_o,
  input logic            dz_o
);
  logic [1:0] cyc;

  // edges since reset release, saturating; gates the $past(.,3) checks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc <= '0;
    else if (cyc != 2'd3)    cyc <= cyc + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (valid_o == $past(valid_i, 3))); // R1

  AST_DZ_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dz_o) |-> (quot_o == '1)); // R3

  AST_DZ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (dz_o == $past(valid_i && (divisor_i == '0), 3))); // R4

  AST_ZERO_DIVIDEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc == 2'd3) && valid_o && $past((dividend_i == '0) && (divisor_i != '0), 3))
      |-> (quot_o == '0)); // R5

  AST_EQUAL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc == 2'd3) && valid_o && $past((dividend_i == divisor_i) && (divisor_i != '0), 3))
      |-> (quot_o == OP_W'(1))); // R6

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!valid_o && !dz_o && (quot_o == '0)); // R8
    end
  end
endmodule

bind apxdiv_top apxdiv_chk #(.OP_W(OP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .dividend_i(dividend_i), .divisor_i(divisor_i),
  .valid_o(valid_o), .quot_o(quot_o), .dz_o(dz_o)
);

// File: tb/sim_apxdiv_top.sv
module sim_apxdiv_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         valid_o;
  logic [W-1:0] quot_o;
  logic         dz_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic         h_v [3];
  logic [W-1:0] h_a [3];
  logic [W-1:0] h_b [3];

  always #10 clk_i = ~clk_i;

  apxdiv_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .valid_o(valid_o), .quot_o(quot_o), .dz_o(dz_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // compares outputs with the input driven three negedges earlier
  task automatic check_out();
    int unsigned a, b, e, q, d;
    if (h_v[2]) begin
      a = h_a[2];
      b = h_b[2];
      q = quot_o;
      chk(valid_o === 1'b1, "R1 valid_o", int'(valid_o), 1);
      if (b == 0) begin
        chk(q == 32'hFFFF, "R3 quot_o", int'(q), 32'hFFFF);
        chk(dz_o === 1'b1, "R3 dz_o", int'(dz_o), 1);
      end else begin
        e = a / b;
        chk(dz_o === 1'b0, "R4 dz_o", int'(dz_o), 0);
        if (a == 0) chk(q == 0, "R5 quot_o", int'(q), 0);
        else if (a == b) chk(q == 1, "R6 quot_o", int'(q), 1);
        else if (is_pow2(a) && is_pow2(b)) chk(q == e, "R7 quot_o", int'(q), int'(e));
        else begin
          d = (q > e) ? q - e : e - q;
          chk(16 * d <= e + 16, "R2 quot_o", int'(q), int'(e));
        end
      end
    end else begin
      chk(valid_o === 1'b0, "R1 valid_o idle", int'(valid_o), 0);
      chk(dz_o === 1'b0, "R4 dz_o idle", int'(dz_o), 0);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    check_out();
    for (int k = 2; k > 0; k--) begin
      h_v[k] = h_v[k-1];
      h_a[k] = h_a[k-1];
      h_b[k] = h_b[k-1];
    end
    h_v[0] = v;
    h_a[0] = a;
    h_b[0] = b;
    valid_i    = v;
    dividend_i = a;
    divisor_i  = b;
  endtask

  function automatic logic [W-1:0] rnd_op();
    int unsigned len;
    len = ($urandom % W) + 1;
    return W'($urandom & ((32'd1 << len) - 1));
  endfunction

  initial begin
    logic [W-1:0] ra, rb;
    int unsigned mode;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      h_v[k] = 1'b0; h_a[k] = '0; h_b[k] = '0;
    end
    repeat (3) begin
      @(negedge clk_i);
      chk(!valid_o && !dz_o && (quot_o == '0), "R8 reset outputs",
          int'({valid_o, dz_o}), 0);
    end
    rst_ni = 1'b1;

    // directed corners, back to back (R1)
    step(1, 16'd100, 16'd0);      // R3
    step(1, 16'd0, 16'd0);        // R3
    step(1, 16'hFFFF, 16'd0);     // R3
    step(1, 16'd0, 16'd7);        // R5
    step(1, 16'hFFFF, 16'hFFFF);  // R6
    step(1, 16'd1, 16'd1);        // R6
    step(1, 16'd12345, 16'd12345);// R6
    step(1, 16'h8000, 16'd1);     // R7
    step(1, 16'd1, 16'h8000);     // R7 below one
    step(1, 16'd256, 16'd4);      // R7
    step(1, 16'hFFFF, 16'd1);     // R2
    step(1, 16'd1, 16'hFFFF);     // R2
    step(1, 16'd3, 16'd2);        // R2
    step(1, 16'hFFFE, 16'd3);     // R2
    step(0, 16'd9, 16'd0);        // R1/R4 idle with zero divisor
    step(1, 16'd40000, 16'd255);  // R2

    for (int n = 0; n < 6000; n++) begin
      mode = $urandom % 16;
      ra = rnd_op();
      rb = rnd_op();
      case (mode)
        0, 1:    step(0, ra, rb);
        2:       step(1, ra, '0);
        3:       step(1, rb, rb);
        4:       step(1, W'(32'd1 << ($urandom % W)), W'(32'd1 << ($urandom % W)));
        5:       step(1, '0, rb | 16'd1);
        default: step(1, ra, (rb == '0) ? 16'd1 : rb);
      endcase
    end
    repeat (4) step(0, '0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule